// File: doc/BRIEF.md
# Dual-Port Control Register Bank

This block holds a small set of 64-bit control and status registers that two requesters share. A sideband configuration port and a memory-mapped port each present a byte address, a write flag, an eight-bit byte-enable and write data for one cycle. Each port turns its byte address into an index in one common register space, with its own rule. Only whole-word accesses are legal, and the data word is carried most significant byte first, with no byte swapping inside the bank.

The bank holds a fault register with AND and OR write aliases, and a control register with set and clear aliases. It also holds a window base register, which only the sideband port may write and which drives the window-enable and window-base outputs, and a secondary base register. A read-only interrupt status word comes in from outside. Several routing and miscellaneous registers are only stored. Every access gets a response in the following cycle. That response carries read data and a one-cycle error flag for any illegal or unimplemented access.

Top module: `reg_bank`

## Requirements
- R1: The sideband index is the byte address shifted right by 3. The memory-mapped index is the byte address shifted right by 3, plus 10 (0x0A), so memory-mapped byte address 0 reaches the window base register.
- R2: An access whose byte-enable is not all ones (8'hFF) is illegal. It changes no register, it raises the error flag, and a read of that kind returns all ones.
- R3: The fault register is at index 0x00. A write to 0x01 ANDs the data into it and a write to 0x02 ORs the data into it.
- R4: The control register is at index 0x0E. A write to 0x12 sets the bits that are one in the data, and a write to 0x13 clears them.
- R5: The window base register at index 0x0A takes writes only from the sideband port. A memory-mapped write to it is dropped and raises the error flag. The window outputs change only after a sideband write.
- R6: The window base register keeps bits 49..20 and bit 0 and clears every other bit. win_en is bit 0 and win_base is bits 49..20 with all other bits zero.
- R7: The secondary base register at index 0x0B keeps only bits 49..32.
- R8: A read of index 0x15 returns the stat_in word. A write to 0x15 has no effect and raises the error flag.
- R9: A read of any index that is neither stored nor 0x15 returns all ones and raises the error flag. This includes the alias indices 0x01, 0x02, 0x12 and 0x13. A write to an index that is neither stored nor an alias has no effect and raises the error flag.
- R10: After reset every register is zero, except the window base register, which holds the masked DEFAULT_BASE with bit 0 set.
- R11: A request in one cycle gives rsp high for exactly the next cycle, with err and rdata valid in that cycle. rdata is zero for an accepted write.
- R12: When both ports write the same register in the same cycle, the sideband write takes effect and the memory-mapped write is dropped without error. Writes to different registers both take effect.
- R13: Indices 0x06, 0x07, 0x0F, 0x10, 0x14 and 0x16..0x1A are plain stored read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sb_req | input | 1 | Sideband request strobe |
| sb_we | input | 1 | Sideband write (1) or read (0) |
| sb_addr | input | ADDR_W | Sideband byte address |
| sb_be | input | 8 | Sideband byte enables |
| sb_wdata | input | 64 | Sideband write data |
| sb_rsp | output | 1 | Sideband response valid |
| sb_rdata | output | 64 | Sideband read data |
| sb_err | output | 1 | Sideband illegal-access pulse |
| mm_req | input | 1 | Memory-mapped request strobe |
| mm_we | input | 1 | Memory-mapped write (1) or read (0) |
| mm_addr | input | ADDR_W | Memory-mapped byte address |
| mm_be | input | 8 | Memory-mapped byte enables |
| mm_wdata | input | 64 | Memory-mapped write data |
| mm_rsp | output | 1 | Memory-mapped response valid |
| mm_rdata | output | 64 | Memory-mapped read data |
| mm_err | output | 1 | Memory-mapped illegal-access pulse |
| stat_in | input | 64 | Live interrupt status word, read at index 0x15 |
| win_en | output | 1 | Window enable |
| win_base | output | 64 | Window base address |

## Verification
Two writes, one from each port, can arrive in the same cycle. They can hit the same register or two different ones, and they can use an alias on one side and a direct write on the other. The bench provokes this by driving both ports on one clock edge. In one case both go to the control register, one through the set alias. In another they go to the fault register and the secondary base register. The result is judged by reading back through the sideband port and by checking that the dropped memory-mapped write reported no error.

// File: rtl/reg_bank_pkg.sv
package reg_bank_pkg;

  localparam int NREG = 32;
  localparam logic [4:0] IX_FAULT  = 5'h00;
  localparam logic [4:0] IX_F_AND  = 5'h01;
  localparam logic [4:0] IX_F_OR   = 5'h02;
  localparam logic [4:0] IX_BASE   = 5'h0A;
  localparam logic [4:0] IX_BASE2  = 5'h0B;
  localparam logic [4:0] IX_CTRL   = 5'h0E;
  localparam logic [4:0] IX_C_SET  = 5'h12;
  localparam logic [4:0] IX_C_CLR  = 5'h13;
  localparam logic [4:0] IX_STAT   = 5'h15;
  localparam int MM_SHIFT_ADD = 10;

  localparam logic [63:0] BASE_ADDR_MASK  = 64'h0003_FFFF_FFF0_0000;
  localparam logic [63:0] BASE2_ADDR_MASK = 64'h0003_FFFF_0000_0000;

  typedef enum logic [1:0] {OP_WR, OP_AND, OP_OR, OP_CLR} wop_e;

  function automatic logic is_store(logic [4:0] i);
    return i inside {5'h00, 5'h06, 5'h07, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                     5'h10, 5'h14, 5'h16, 5'h17, 5'h18, 5'h19, 5'h1A};
  endfunction

  function automatic logic [63:0] keep_mask(logic [4:0] i);
    if (i == IX_BASE)  return BASE_ADDR_MASK | 64'h1;
    if (i == IX_BASE2) return BASE2_ADDR_MASK;
    return '1;
  endfunction

  function automatic logic [63:0] apply_op(wop_e op, logic [63:0] old_v,
                                           logic [63:0] d);
    case (op)
      OP_AND:  return old_v & d;
      OP_OR:   return old_v | d;
      OP_CLR:  return old_v & ~d;
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] sb_index(logic [31:0] a);
    return a >> 3;
  endfunction

  function automatic logic [31:0] mm_index(logic [31:0] a);
    return (a >> 3) + 32'(MM_SHIFT_ADD);
  endfunction

endpackage

// File: rtl/port_decode.sv
module port_decode
  import reg_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter bit IS_MM  = 1'b0
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        be,
  output logic              wr_hit,
  output logic [4:0]        wr_tgt,
  output wop_e              wr_op,
  output logic              rd_hit,
  output logic [4:0]        rd_idx,
  output logic              bad
);
  logic [31:0] idx32;
  logic [4:0]  idx;
  logic        in_range, full, rd_ok, wr_ok, alias_hit;

  generate
    if (IS_MM) begin : g_mm
      assign idx32 = mm_index(32'(addr));
    end else begin : g_sb
      assign idx32 = sb_index(32'(addr));
    end
  endgenerate

  assign idx      = idx32[4:0];
  assign in_range = (idx32 < 32'(NREG));
  assign full     = &be;

  always_comb begin
    alias_hit = 1'b1;
    wr_tgt    = idx;
    wr_op     = OP_WR;
    case (idx)
      IX_F_AND: begin wr_tgt = IX_FAULT; wr_op = OP_AND; end
      IX_F_OR:  begin wr_tgt = IX_FAULT; wr_op = OP_OR;  end
      IX_C_SET: begin wr_tgt = IX_CTRL;  wr_op = OP_OR;  end
      IX_C_CLR: begin wr_tgt = IX_CTRL;  wr_op = OP_CLR; end
      default:  alias_hit = 1'b0;
    endcase
  end

  assign rd_ok  = in_range && (is_store(idx) || idx == IX_STAT);
  assign wr_ok  = in_range && (is_store(idx) || alias_hit) &&
                  !(IS_MM && idx == IX_BASE);
  assign rd_idx = idx;
  assign wr_hit = req && we && full && wr_ok;
  assign rd_hit = req && !we && full && rd_ok;
  assign bad    = req && !(full && (we ? wr_ok : rd_ok));
endmodule

// File: rtl/reg_core.sv
module reg_core
  import reg_bank_pkg::*;
#(
  parameter logic [63:0] DEFAULT_BASE = 64'h0000_0006_0300_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_hit,
  input  logic [4:0]  a_tgt,
  input  wop_e        a_op,
  input  logic [63:0] a_wd,
  input  logic        b_hit,
  input  logic [4:0]  b_tgt,
  input  wop_e        b_op,
  input  logic [63:0] b_wd,
  input  logic [4:0]  a_ridx,
  input  logic [4:0]  b_ridx,
  input  logic [63:0] stat_in,
  output logic [63:0] a_rval,
  output logic [63:0] b_rval,
  output logic [63:0] base_q,
  output logic        b_lost
);
  localparam logic [63:0] BASE_RST = (DEFAULT_BASE & BASE_ADDR_MASK) | 64'h1;

  logic [63:0] bank [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        bank[i] <= (5'(i) == IX_BASE) ? BASE_RST : 64'h0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (is_store(5'(i))) begin
          if (a_hit && a_tgt == 5'(i))
            bank[i] <= apply_op(a_op, bank[i], a_wd) & keep_mask(5'(i));
          else if (b_hit && b_tgt == 5'(i))
            bank[i] <= apply_op(b_op, bank[i], b_wd) & keep_mask(5'(i));
        end
      end
    end
  end

  assign a_rval = (a_ridx == IX_STAT) ? stat_in : bank[a_ridx];
  assign b_rval = (b_ridx == IX_STAT) ? stat_in : bank[b_ridx];
  assign base_q = bank[IX_BASE];
  assign b_lost = a_hit && b_hit && (a_tgt == b_tgt);
endmodule

// File: rtl/port_rsp.sv
module port_rsp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic        rd_hit,
  input  logic        bad,
  input  logic [63:0] rval,
  output logic        rsp,
  output logic [63:0] rdata,
  output logic        err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      rsp   <= req;
      err   <= bad;
      if (rd_hit)         rdata <= rval;
      else if (req && !we) rdata <= '1;
      else                rdata <= '0;
    end
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import reg_bank_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter logic [63:0] DEFAULT_BASE = 64'h0000_0006_0300_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sb_req,
  input  logic              sb_we,
  input  logic [ADDR_W-1:0] sb_addr,
  input  logic [7:0]        sb_be,
  input  logic [63:0]       sb_wdata,
  output logic              sb_rsp,
  output logic [63:0]       sb_rdata,
  output logic              sb_err,
  input  logic              mm_req,
  input  logic              mm_we,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [7:0]        mm_be,
  input  logic [63:0]       mm_wdata,
  output logic              mm_rsp,
  output logic [63:0]       mm_rdata,
  output logic              mm_err,
  input  logic [63:0]       stat_in,
  output logic              win_en,
  output logic [63:0]       win_base
);
  logic sb_wr_hit, sb_rd_hit, sb_bad, mm_wr_hit, mm_rd_hit, mm_bad, mm_lost;
  logic [4:0]  sb_tgt, sb_ridx, mm_tgt, mm_ridx;
  wop_e        sb_op, mm_op;
  logic [63:0] sb_rval, mm_rval, base_q;

  port_decode #(.ADDR_W(ADDR_W), .IS_MM(1'b0)) u_sb_dec (
    .req(sb_req), .we(sb_we), .addr(sb_addr), .be(sb_be),
    .wr_hit(sb_wr_hit), .wr_tgt(sb_tgt), .wr_op(sb_op),
    .rd_hit(sb_rd_hit), .rd_idx(sb_ridx), .bad(sb_bad));

  port_decode #(.ADDR_W(ADDR_W), .IS_MM(1'b1)) u_mm_dec (
    .req(mm_req), .we(mm_we), .addr(mm_addr), .be(mm_be),
    .wr_hit(mm_wr_hit), .wr_tgt(mm_tgt), .wr_op(mm_op),
    .rd_hit(mm_rd_hit), .rd_idx(mm_ridx), .bad(mm_bad));

  reg_core #(.DEFAULT_BASE(DEFAULT_BASE)) u_core (
    .clk(clk), .rst_n(rst_n),
    .a_hit(sb_wr_hit), .a_tgt(sb_tgt), .a_op(sb_op), .a_wd(sb_wdata),
    .b_hit(mm_wr_hit), .b_tgt(mm_tgt), .b_op(mm_op), .b_wd(mm_wdata),
    .a_ridx(sb_ridx), .b_ridx(mm_ridx), .stat_in(stat_in),
    .a_rval(sb_rval), .b_rval(mm_rval), .base_q(base_q), .b_lost(mm_lost));

  port_rsp u_sb_rsp (
    .clk(clk), .rst_n(rst_n), .req(sb_req), .we(sb_we), .rd_hit(sb_rd_hit),
    .bad(sb_bad), .rval(sb_rval), .rsp(sb_rsp), .rdata(sb_rdata), .err(sb_err));

  port_rsp u_mm_rsp (
    .clk(clk), .rst_n(rst_n), .req(mm_req), .we(mm_we), .rd_hit(mm_rd_hit),
    .bad(mm_bad), .rval(mm_rval), .rsp(mm_rsp), .rdata(mm_rdata), .err(mm_err));

  assign win_en   = base_q[0];
  assign win_base = base_q & BASE_ADDR_MASK;
endmodule

// File: rtl/reg_bank_chk.sv
module reg_bank_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sb_req,
  input logic              sb_we,
  input logic [ADDR_W-1:0] sb_addr,
  input logic [7:0]        sb_be,
  input logic              sb_rsp,
  input logic [63:0]       sb_rdata,
  input logic              sb_err,
  input logic              mm_req,
  input logic [7:0]        mm_be,
  input logic              mm_rsp,
  input logic              mm_err,
  input logic              mm_lost,
  input logic              win_en,
  input logic [63:0]       win_base
);
  // R11: every sideband request gets a response in the next cycle
  a_r11_sb_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req |=> sb_rsp);

  // R11: no memory-mapped request, no response and no error next cycle
  a_r11_mm_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mm_req |=> (!mm_rsp && !mm_err));

  // R5: the window outputs move only after a sideband write
  a_r5_win_sb_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(sb_req && sb_we) |=> ($stable(win_en) && $stable(win_base)));

  // R2: a partial byte-enable is reported
  a_r2_partial_err: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && mm_be != 8'hFF) |=> mm_err);

  // R9: a read of unimplemented index 3 gives all ones and an error
  a_r9_unimpl_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && !sb_we && (&sb_be) && (sb_addr >> 3) == ADDR_W'(3))
    |=> (sb_err && (&sb_rdata)));

  // R12: a memory-mapped write lost to the sideband is not an error
  a_r12_lost_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    mm_lost |=> !mm_err);
endmodule

bind reg_bank reg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sb_req(sb_req), .sb_we(sb_we),
  .sb_addr(sb_addr), .sb_be(sb_be), .sb_rsp(sb_rsp), .sb_rdata(sb_rdata),
  .sb_err(sb_err), .mm_req(mm_req), .mm_be(mm_be), .mm_rsp(mm_rsp),
  .mm_err(mm_err), .mm_lost(mm_lost), .win_en(win_en), .win_base(win_base));

// File: tb/tb_reg_bank.sv
module tb_reg_bank;
  localparam int ADDR_W = 16;
  localparam logic [63:0] DEF_BASE = 64'h0000_0006_0300_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sb_req = 0, sb_we = 0, mm_req = 0, mm_we = 0;
  logic [ADDR_W-1:0] sb_addr = '0, mm_addr = '0;
  logic [7:0]  sb_be = '0, mm_be = '0;
  logic [63:0] sb_wdata = '0, mm_wdata = '0, stat_in = '0;
  logic        sb_rsp, sb_err, mm_rsp, mm_err, win_en;
  logic [63:0] sb_rdata, mm_rdata, win_base;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] r_data;
  logic r_err, r_rsp;

  always #5 clk = ~clk;

  reg_bank #(.ADDR_W(ADDR_W), .DEFAULT_BASE(DEF_BASE)) dut (.*);

  function automatic logic [ADDR_W-1:0] sa(int ix); return ADDR_W'(ix * 8); endfunction
  function automatic logic [ADDR_W-1:0] ma(int ix); return ADDR_W'((ix - 10) * 8); endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sb_acc(logic we, logic [ADDR_W-1:0] a, logic [7:0] be, logic [63:0] d);
    @(negedge clk);
    sb_req = 1; sb_we = we; sb_addr = a; sb_be = be; sb_wdata = d;
    @(negedge clk);
    sb_req = 0; r_data = sb_rdata; r_err = sb_err; r_rsp = sb_rsp;
  endtask

  task automatic mm_acc(logic we, logic [ADDR_W-1:0] a, logic [7:0] be, logic [63:0] d);
    @(negedge clk);
    mm_req = 1; mm_we = we; mm_addr = a; mm_be = be; mm_wdata = d;
    @(negedge clk);
    mm_req = 0; r_data = mm_rdata; r_err = mm_err; r_rsp = mm_rsp;
  endtask

  task automatic sb_read_chk(string tag, int ix, logic [63:0] exp);
    sb_acc(0, sa(ix), 8'hFF, 0);
    chk(tag, r_data, exp);
  endtask

  task automatic t_reset();
    sb_read_chk("R10 base reset", 10, DEF_BASE | 64'h1);
    chk("R10 win_en", 64'(win_en), 64'h1);
    chk("R10 win_base", win_base, DEF_BASE);
    sb_read_chk("R10 fault reset", 0, 64'h0);
    sb_read_chk("R10 ctrl reset", 14, 64'h0);
  endtask

  task automatic t_fault();
    sb_acc(1, sa(0), 8'hFF, 64'hF0F0);
    sb_acc(1, sa(1), 8'hFF, 64'hFF00);
    sb_read_chk("R3 and alias", 0, 64'hF000);
    sb_acc(1, sa(2), 8'hFF, 64'h000F);
    sb_read_chk("R3 or alias", 0, 64'hF00F);
  endtask

  task automatic t_ctrl();
    mm_acc(1, ma(14), 8'hFF, 64'h1);
    chk("R11 write rsp", 64'(r_rsp), 64'h1);
    chk("R11 write rdata zero", r_data, 64'h0);
    @(negedge clk);
    chk("R11 rsp one cycle", 64'(mm_rsp), 64'h0);
    sb_acc(1, sa(18), 8'hFF, 64'h30);
    mm_acc(0, ma(14), 8'hFF, 0);
    chk("R4 set alias via R1 mm index", r_data, 64'h31);
    mm_acc(1, ma(19), 8'hFF, 64'h11);
    sb_read_chk("R4 clear alias", 14, 64'h20);
  endtask

  task automatic t_base();
    mm_acc(1, 16'h0000, 8'hFF, 64'h0);
    chk("R5 mm base write err", 64'(r_err), 64'h1);
    chk("R5 win_en kept", 64'(win_en), 64'h1);
    mm_acc(0, 16'h0000, 8'hFF, 0);
    chk("R1 mm addr 0 reads base", r_data, DEF_BASE | 64'h1);
    sb_acc(1, sa(10), 8'hFF, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R6 win_en off", 64'(win_en), 64'h0);
    chk("R6 win_base mask", win_base, 64'h0003_FFFF_FFF0_0000);
    sb_read_chk("R6 base stored mask", 10, 64'h0003_FFFF_FFF0_0000);
    sb_acc(1, sa(10), 8'hFF, 64'h0000_0001_2345_6789);
    chk("R6 win_en on", 64'(win_en), 64'h1);
    chk("R6 win_base", win_base, 64'h0000_0001_2340_0000);
    mm_acc(1, ma(11), 8'hFF, '1);
    sb_read_chk("R7 base2 mask", 11, 64'h0003_FFFF_0000_0000);
  endtask

  task automatic t_stat_unimpl();
    stat_in = 64'hDEAD_BEEF_0000_1234;
    mm_acc(0, ma(21), 8'hFF, 0);
    chk("R8 stat read", r_data, 64'hDEAD_BEEF_0000_1234);
    sb_acc(1, sa(21), 8'hFF, 64'h0);
    chk("R8 stat write err", 64'(r_err), 64'h1);
    sb_read_chk("R8 stat unchanged", 21, 64'hDEAD_BEEF_0000_1234);
    sb_acc(0, sa(3), 8'hFF, 0);
    chk("R9 unimpl read ones", r_data, '1);
    chk("R9 unimpl read err", 64'(r_err), 64'h1);
    sb_acc(0, sa(18), 8'hFF, 0);
    chk("R9 alias read ones", r_data, '1);
    sb_acc(1, sa(5), 8'hFF, 64'h1234);
    chk("R9 unimpl write err", 64'(r_err), 64'h1);
    sb_read_chk("R9 fault untouched", 0, 64'hF00F);
  endtask

  task automatic t_partial();
    sb_acc(1, sa(0), 8'h0F, 64'h0);
    chk("R2 partial write err", 64'(r_err), 64'h1);
    sb_read_chk("R2 fault untouched", 0, 64'hF00F);
    mm_acc(0, ma(14), 8'hFE, 0);
    chk("R2 partial read ones", r_data, '1);
    chk("R2 partial read err", 64'(r_err), 64'h1);
  endtask

  task automatic t_plain();
    mm_acc(1, ma(22), 8'hFF, 64'hCAFE_F00D_1111_2222);
    sb_read_chk("R13 plain reg", 22, 64'hCAFE_F00D_1111_2222);
    sb_acc(1, sa(7), 8'hFF, 64'h77);
    sb_read_chk("R13 plain reg low", 7, 64'h77);
  endtask

  task automatic t_both();
    @(negedge clk);
    sb_req = 1; sb_we = 1; sb_addr = sa(14); sb_be = 8'hFF; sb_wdata = 64'hAAAA;
    mm_req = 1; mm_we = 1; mm_addr = ma(18); mm_be = 8'hFF; mm_wdata = 64'h5555;
    @(negedge clk);
    sb_req = 0; mm_req = 0;
    chk("R12 lost write no err", 64'(mm_err), 64'h0);
    sb_read_chk("R12 sideband wins", 14, 64'hAAAA);
    @(negedge clk);
    sb_req = 1; sb_we = 1; sb_addr = sa(2); sb_be = 8'hFF; sb_wdata = 64'h0100;
    mm_req = 1; mm_we = 1; mm_addr = ma(11); mm_be = 8'hFF; mm_wdata = 64'h0000_0005_0000_0000;
    @(negedge clk);
    sb_req = 0; mm_req = 0;
    sb_read_chk("R12 both apply fault", 0, 64'hF10F);
    sb_read_chk("R12 both apply base2", 11, 64'h0000_0005_0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fault();
    t_ctrl();
    t_base();
    t_stat_unimpl();
    t_partial();
    t_plain();
    t_both();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule